// File: doc/BRIEF.md
# Serial EEPROM Command and Address-Pointer Sequencer

This block holds the byte-level command logic of a single-wire serial EEPROM slave. A bit-level decoder in front of it delivers each received byte with a one-cycle valid strobe. The decoder also raises one-cycle strobes when the master acknowledges (MAK), when it declines to acknowledge (NoMAK), and when it sends a standby pulse. The sequencer checks the framing bytes that open every transaction and decodes three commands: random read, write, and read from the current pointer. It keeps a persistent address pointer and drives a plain read/write port into a 256-byte array. It hands each byte fetched for the master to the transmit side.

The pointer takes a new value only when the master acknowledges an address byte. It advances only when the master answers a data byte with MAK or NoMAK. A standby pulse never changes it. Because the pointer persists, a current-pointer read can resume a sequence that an earlier command left off. Reads advance across the whole array. Writes stay inside a 16-byte page.

Top module: `ee_addr_seq`

## Requirements
- R1: After reset the sequencer waits for a standby pulse. Until one arrives it ignores every byte and acknowledge strobe, and it raises no memory access and no transmit strobe.
- R2: After a standby pulse the first byte must be 0x55 and the second must be 0xA0. Any other value sends the sequencer to a waiting state that ignores all input except the next standby pulse.
- R3: The third byte selects the command: 0x03 is a read with an address byte, 0x6C is a write with an address byte, and 0x06 is a read from the current pointer with no address byte. Any other code sends the sequencer to the waiting state.
- R4: In a read or write, a MAK after the address byte loads the pointer with that byte. A NoMAK in its place ends the command and leaves the pointer unchanged.
- R5: For every byte a read supplies, mem_re is high for one cycle with mem_addr equal to the pointer. In the next cycle tx_valid is high and tx_byte equals mem_rdata. A MAK after the byte requests the next byte, and a NoMAK ends the command.
- R6: In any of the three commands, a MAK or a NoMAK after a data byte advances the pointer by one.
- R7: A standby pulse in place of the acknowledge after a data byte leaves the pointer unchanged.
- R8: In a write, the pointer step changes only the low 4 bits, so address 0x3F is followed by 0x30.
- R9: In a read, the pointer step covers the whole array, so address 0xFF is followed by 0x00.
- R10: A standby pulse in any state restarts the header check. In the cycle after the pulse there is no memory read and no transmit strobe.
- R11: In a write, each data byte is written in the cycle it arrives: mem_we is high, mem_addr equals the pointer and mem_wdata equals the byte.
- R12: mem_re and mem_we are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_byte | input | 8 | Byte received from the bit decoder |
| rx_valid | input | 1 | One-cycle strobe marking rx_byte as new |
| mak | input | 1 | One-cycle strobe: the master acknowledged |
| nomak | input | 1 | One-cycle strobe: the master did not acknowledge |
| sby | input | 1 | One-cycle strobe: a standby pulse was seen |
| mem_addr | output | 8 | Array address, always the current pointer |
| mem_re | output | 1 | Array read request, data expected one cycle later |
| mem_we | output | 1 | Array write enable |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid the cycle after mem_re |
| tx_byte | output | 8 | Byte handed to the transmit side |
| tx_valid | output | 1 | One-cycle strobe marking tx_byte as new |

## Verification
On every cycle the assertions check the pointer rules: a standby pulse never moves the pointer, a read step wraps over the full array, and a write step stays inside its page. They also check the one-cycle gap from read request to transmit strobe, the quiet cycle after a standby pulse, the rejection of a bad start byte, and that reads and writes never overlap. Some behaviour only the bench's scenarios can show. These include the byte values that end up on tx_byte, the address sequences of a wrapping write, and whether a current-pointer read resumes at the right place after a NoMAK, a standby pulse, or a rejected header.

// File: rtl/ee_addr_seq.sv
module ee_addr_seq #(
  parameter int          AW        = 8,
  parameter int          PAGE_BITS = 4,
  parameter logic [7:0]  HDR_CODE  = 8'h55,
  parameter logic [7:0]  DEV_CODE  = 8'hA0,
  parameter logic [7:0]  CMD_RD    = 8'h03,
  parameter logic [7:0]  CMD_WR    = 8'h6C,
  parameter logic [7:0]  CMD_CUR   = 8'h06
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rx_byte,
  input  logic          rx_valid,
  input  logic          mak,
  input  logic          nomak,
  input  logic          sby,
  output logic [AW-1:0] mem_addr,
  output logic          mem_re,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  output logic [7:0]    tx_byte,
  output logic          tx_valid
);
  localparam logic [3:0] S_HOLD  = 4'd0, S_HDR    = 4'd1, S_DEV  = 4'd2,
                         S_CMD   = 4'd3, S_ADR    = 4'd4, S_ADRA = 4'd5,
                         S_RDREQ = 4'd6, S_RDWAIT = 4'd7, S_WDAT = 4'd8,
                         S_WACK  = 4'd9;
  localparam logic [AW-1:0]        ONE  = 1;
  localparam logic [PAGE_BITS-1:0] PONE = 1;

  logic [3:0]    st, st_nx;
  logic [AW-1:0] ptr, adr_q;
  logic          wr_cmd, re_q;

  wire           ack      = mak | nomak;
  wire [AW-1:0]  ptr_seq  = ptr + ONE;
  wire [AW-1:0]  ptr_page = {ptr[AW-1:PAGE_BITS], ptr[PAGE_BITS-1:0] + PONE};

  always_comb begin
    st_nx = st;
    if (sby) st_nx = S_HDR;
    else begin
      case (st)
        S_HOLD:   st_nx = S_HOLD;
        S_HDR:    if (rx_valid) st_nx = (rx_byte == HDR_CODE) ? S_DEV : S_HOLD;
        S_DEV:    if (rx_valid) st_nx = (rx_byte == DEV_CODE) ? S_CMD : S_HOLD;
        S_CMD:    if (rx_valid) begin
                    case (rx_byte)
                      CMD_RD, CMD_WR: st_nx = S_ADR;
                      CMD_CUR:        st_nx = S_RDREQ;
                      default:        st_nx = S_HOLD;
                    endcase
                  end
        S_ADR:    if (rx_valid) st_nx = S_ADRA;
        S_ADRA:   if (mak) st_nx = wr_cmd ? S_WDAT : S_RDREQ;
                  else if (nomak) st_nx = S_HOLD;
        S_RDREQ:  st_nx = S_RDWAIT;
        S_RDWAIT: if (mak) st_nx = S_RDREQ;
                  else if (nomak) st_nx = S_HOLD;
        S_WDAT:   if (rx_valid) st_nx = S_WACK;
        S_WACK:   if (mak) st_nx = S_WDAT;
                  else if (nomak) st_nx = S_HOLD;
        default:  st_nx = S_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_HOLD;
      ptr    <= '0;
      adr_q  <= '0;
      wr_cmd <= 1'b0;
      re_q   <= 1'b0;
    end else begin
      st   <= st_nx;
      re_q <= mem_re;
      if (!sby) begin
        if (st == S_CMD && rx_valid) wr_cmd <= (rx_byte == CMD_WR);
        if (st == S_ADR && rx_valid) adr_q  <= rx_byte[AW-1:0];
        if (st == S_ADRA && mak)          ptr <= adr_q;
        else if (st == S_RDWAIT && ack)   ptr <= ptr_seq;
        else if (st == S_WACK && ack)     ptr <= ptr_page;
      end
    end
  end

  assign mem_addr  = ptr;
  assign mem_re    = (st == S_RDREQ) && !sby;
  assign mem_we    = (st == S_WDAT) && rx_valid && !sby;
  assign mem_wdata = rx_byte;
  assign tx_byte   = mem_rdata;
  assign tx_valid  = re_q;
endmodule

// File: rtl/ee_addr_seq_chk.sv
module ee_addr_seq_chk #(
  parameter int         AW        = 8,
  parameter int         PAGE_BITS = 4,
  parameter logic [7:0] HDR_CODE  = 8'h55
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sby,
  input logic          mak,
  input logic          nomak,
  input logic          rx_valid,
  input logic [7:0]    rx_byte,
  input logic [3:0]    st,
  input logic [AW-1:0] ptr,
  input logic          mem_re,
  input logic          mem_we,
  input logic          tx_valid
);
  localparam logic [3:0] C_HOLD = 4'd0, C_HDR = 4'd1, C_RDWAIT = 4'd7, C_WACK = 4'd9;
  localparam logic [AW-1:0]        ONE  = 1;
  localparam logic [PAGE_BITS-1:0] PONE = 1;

  // R1
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HOLD && !sby) |=> (st == C_HOLD && !mem_re && !mem_we));
  // R2
  hdr_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_HDR && rx_valid && rx_byte != HDR_CODE && !sby) |=> st == C_HOLD);
  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> tx_valid);
  // R7
  sby_hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sby |=> ptr == $past(ptr));
  // R8
  wr_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_WACK && (mak || nomak) && !sby) |=>
      (ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS]) &&
       ptr[PAGE_BITS-1:0] == $past(ptr[PAGE_BITS-1:0]) + PONE));
  // R9
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RDWAIT && (mak || nomak) && !sby) |=> ptr == $past(ptr) + ONE);
  // R10
  sby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sby |=> (!tx_valid && !mem_re && st == C_HDR));
  // R12
  rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_re && mem_we));
endmodule

bind ee_addr_seq ee_addr_seq_chk #(.AW(AW), .PAGE_BITS(PAGE_BITS), .HDR_CODE(HDR_CODE)) u_chk (
  .clk(clk), .rst_n(rst_n), .sby(sby), .mak(mak), .nomak(nomak),
  .rx_valid(rx_valid), .rx_byte(rx_byte), .st(st), .ptr(ptr),
  .mem_re(mem_re), .mem_we(mem_we), .tx_valid(tx_valid));

// File: tb/sim_ee_addr_seq.sv
module sim_ee_addr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic rx_valid = 1'b0, mak = 1'b0, nomak = 1'b0, sby = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata, tx_byte;
  logic mem_re, mem_we, tx_valid;

  int checks = 0, errors = 0;
  int re_cnt = 0, wr_cnt = 0, tx_cnt = 0, tx_rd = 0, wr_rd = 0;
  logic [7:0] mem [256];
  logic [7:0] tx_log [64];
  logic [7:0] wa_log [64];
  logic [7:0] wd_log [64];
  bit finished = 0;

  always #5 clk = ~clk;

  ee_addr_seq u0 (.clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .mak(mak), .nomak(nomak), .sby(sby), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .tx_byte(tx_byte), .tx_valid(tx_valid));

  function automatic logic [7:0] f(input logic [7:0] a);
    return a ^ 8'h5A;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = f(8'(i));
    mem_rdata = 8'h00;
  end

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (mem_re) re_cnt++;
    if (mem_we) begin
      wa_log[wr_cnt[5:0]] = mem_addr;
      wd_log[wr_cnt[5:0]] = mem_wdata;
      wr_cnt++;
    end
    if (tx_valid) begin
      tx_log[tx_cnt[5:0]] = tx_byte;
      tx_cnt++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    @(posedge clk); #2; rx_byte = b; rx_valid = 1'b1;
    @(posedge clk); #2; rx_valid = 1'b0;
  endtask

  task automatic p_mak;
    @(posedge clk); #2; mak = 1'b1; @(posedge clk); #2; mak = 1'b0;
  endtask

  task automatic p_nomak;
    @(posedge clk); #2; nomak = 1'b1; @(posedge clk); #2; nomak = 1'b0;
  endtask

  task automatic p_sby;
    @(posedge clk); #2; sby = 1'b1; @(posedge clk); #2; sby = 1'b0;
  endtask

  task automatic open_cmd(input logic [7:0] cmd);
    p_sby; send(8'h55); send(8'hA0); send(cmd);
  endtask

  task automatic take_tx(input string req, input logic [7:0] exp);
    idle(3);
    if (tx_rd >= tx_cnt) begin
      checks++; errors++;
      $display("FAIL %s actual=none expected=%0h", req, exp);
    end else begin
      chk(req, int'(tx_log[tx_rd[5:0]]), int'(exp));
      tx_rd++;
    end
  endtask

  task automatic take_wr(input string req, input logic [7:0] a, input logic [7:0] d);
    if (wr_rd >= wr_cnt) begin
      checks++; errors++;
      $display("FAIL %s actual=none expected=%0h", req, a);
    end else begin
      chk(req, int'(wa_log[wr_rd[5:0]]), int'(a));
      chk(req, int'(wd_log[wr_rd[5:0]]), int'(d));
      wr_rd++;
    end
  endtask

  task automatic t_reset;
    idle(1);
    chk("R1 mem_re after reset", int'(mem_re), 0);
    chk("R1 tx_valid after reset", int'(tx_valid), 0);
    send(8'h55); send(8'hA0); send(8'h06); p_mak; idle(3);
    chk("R1 reads before standby", re_cnt, 0);
    chk("R1 tx before standby", tx_cnt, 0);
  endtask

  task automatic t_read;
    open_cmd(8'h03); send(8'h20); p_mak;
    take_tx("R4 R5 first byte of random read", f(8'h20));
    p_mak;
    take_tx("R5 R6 second byte", f(8'h21));
    p_nomak; idle(2);
    open_cmd(8'h06);
    take_tx("R3 R6 current read after NoMAK", f(8'h22));
    open_cmd(8'h06);
    take_tx("R7 standby did not advance", f(8'h22));
    p_mak;
    take_tx("R6 current read continues", f(8'h23));
    p_nomak; idle(2);
  endtask

  task automatic t_write_wrap;
    open_cmd(8'h6C); send(8'h3E); p_mak;
    send(8'hA1); p_mak; send(8'hB2); p_mak; send(8'hC3); p_mak; send(8'hD4); p_nomak;
    idle(2);
    take_wr("R11 write 0", 8'h3E, 8'hA1);
    take_wr("R11 write 1", 8'h3F, 8'hB2);
    take_wr("R8 page wrap write", 8'h30, 8'hC3);
    take_wr("R8 after wrap", 8'h31, 8'hD4);
    open_cmd(8'h06);
    take_tx("R8 pointer stayed in page", f(8'h32));
    open_cmd(8'h03); send(8'h3F); p_mak;
    take_tx("R11 written data read back", 8'hB2);
    p_nomak; idle(2);
  endtask

  task automatic t_read_wrap;
    open_cmd(8'h03); send(8'hFF); p_mak;
    take_tx("R9 byte at top", f(8'hFF));
    p_mak;
    take_tx("R9 full-array wrap", f(8'h00));
    p_nomak; idle(2);
    open_cmd(8'h06);
    take_tx("R9 pointer after wrap", f(8'h01));
  endtask

  task automatic t_bad_frames;
    int r0, t0;
    r0 = re_cnt; t0 = tx_cnt;
    p_sby; send(8'h54); send(8'hA0); send(8'h06); idle(3);
    chk("R2 bad start byte ignored", re_cnt, r0);
    p_sby; send(8'h55); send(8'hA1); send(8'h06); idle(3);
    chk("R2 bad device byte ignored", re_cnt, r0);
    p_sby; send(8'h55); send(8'hA0); send(8'h07); send(8'h06); idle(3);
    chk("R3 unknown command ignored", re_cnt, r0);
    chk("R2 R3 no transmit after rejects", tx_cnt, t0);
    open_cmd(8'h06);
    take_tx("R2 recovery after standby", f(8'h01));
  endtask

  task automatic t_addr_nomak;
    int r0;
    open_cmd(8'h03); send(8'h80); r0 = re_cnt; p_nomak; idle(3);
    chk("R4 NoMAK on address reads nothing", re_cnt, r0);
    open_cmd(8'h06);
    take_tx("R4 pointer not loaded", f(8'h01));
  endtask

  task automatic t_sby_write;
    int t0;
    open_cmd(8'h6C); send(8'h10); p_mak; send(8'hEE);
    take_wr("R11 write before standby", 8'h10, 8'hEE);
    p_sby;
    t0 = tx_cnt; idle(1);
    chk("R10 no transmit after standby", tx_cnt, t0);
    send(8'h55); send(8'hA0); send(8'h06);
    take_tx("R7 write pointer kept on standby", 8'hEE);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    #2 rst_n = 1'b1;
    t_reset;
    t_read;
    t_write_wrap;
    t_read_wrap;
    t_bad_frames;
    t_addr_nomak;
    t_sby_write;
    idle(2);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule